// File: doc/BRIEF.md
# IOMMU Configuration Register Bank

This block holds the two 64-bit configuration registers that steer an I/O address translation walker: a control word and a translation-table base address. Software reaches them over a simple memory-mapped access port that carries either a full 8-byte access or a 4-byte access to one half of a register. The bus is big-endian, so a 4-byte access at a register's 8-aligned offset targets its upper half, and a 4-byte access 4 bytes further on targets its lower half.

Both register values are driven continuously to the walker. A flush location is also decoded. Writes to it are accepted and have no effect, and reads from it return zero. Any other access is refused. It returns zero, changes no state and raises a one-cycle error strobe.

Read data, its valid flag and the error strobe are registered. They appear one clock after the access is presented. A register write is visible on the walker outputs from the cycle after the write.

Top module: `iommu_cfg_bank`

## Requirements
- R1: An 8-byte write at offset 0x00 (control) or 0x08 (table base) replaces the whole 64-bit register with `acc_wdata`. The new value is on `walker_ctrl`/`walker_base` one clock after the write.
- R2: A 4-byte write at offset 0x00 or 0x08 loads `acc_wdata[31:0]` into bits [63:32] of that register and leaves bits [31:0] unchanged.
- R3: A 4-byte write at offset 0x04 or 0x0C loads `acc_wdata[31:0]` into bits [31:0] of the register at 0x00 or 0x08 and leaves bits [63:32] unchanged.
- R4: A read raises `rd_valid` for one clock, one clock after it is presented, with `rd_data` holding the result. An 8-byte read returns the full register. A 4-byte read at 0x00/0x08 returns bits [63:32] in `rd_data[31:0]`, and one at 0x04/0x0C returns bits [31:0]. In both cases `rd_data[63:32]` is zero. `rd_valid` stays low when no read is presented.
- R5: The flush location accepts an 8-byte access at 0x10 and 4-byte accesses at 0x10 and 0x14. Writes there change neither register, reads return zero, and `bad_access` stays low.
- R6: Reset (`rst_n` low, asynchronous) clears both registers to zero, so translation starts out disabled. It also clears `rd_valid`, `rd_data` and `bad_access`.
- R7: An access is unmapped in three cases: its offset is not a multiple of 4, its offset lies at 0x18 or above, or it is an 8-byte access at an offset whose bit 2 is set. An unmapped read returns zero. An unmapped write changes no register. In both cases `bad_access` is high for exactly one clock, one clock after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| acc_offset | input | ADDR_W | Byte offset within the bank |
| acc_wdata | input | 64 | Write data (4-byte writes use bits [31:0]) |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| bad_access | output | 1 | One-cycle strobe for an unmapped access |
| walker_ctrl | output | 64 | Current control register |
| walker_base | output | 64 | Current table-base register |

## Verification
The registers are first loaded with 8-byte writes of distinct patterns, so that a swapped or truncated path shows up. Each half is then overwritten separately with a value whose halves differ from the old content. This separates a correct merge from one that clobbers or swaps the other half. Reads of every view (full, upper, lower) are compared through a queue against a model. Flush accesses and several kinds of unmapped access (misaligned, out of range, wide at a +4 offset) are sent as well, so that a decoder which treats one of them as a register hit can be told apart from one that refuses it.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int REG_W  = 64;
  localparam int HALF_W = REG_W / 2;
  localparam int NREGS  = 2;
  // 8-byte word indices within the bank
  localparam int CTRL_WORD  = 0;
  localparam int BASE_WORD  = 1;
  localparam int FLUSH_WORD = 2;

  typedef enum logic [1:0] {TGT_CTRL = 2'd0, TGT_BASE = 2'd1,
                            TGT_FLUSH = 2'd2, TGT_NONE = 2'd3} target_e;
  typedef enum logic [1:0] {LANE_FULL = 2'd0, LANE_HI = 2'd1,
                            LANE_LO = 2'd2} lane_e;

  // merge incoming write data into an existing register value
  function automatic logic [REG_W-1:0] merge_write(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] wd,
                                                   input lane_e ln);
    case (ln)
      LANE_HI: merge_write = {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
      LANE_LO: merge_write = {old_v[REG_W-1:HALF_W], wd[HALF_W-1:0]};
      default: merge_write = wd;
    endcase
  endfunction

  // view of a register as seen by a read of the given width/half
  function automatic logic [REG_W-1:0] read_view(input logic [REG_W-1:0] v,
                                                 input lane_e ln);
    case (ln)
      LANE_HI: read_view = {{HALF_W{1'b0}}, v[REG_W-1:HALF_W]};
      LANE_LO: read_view = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
      default: read_view = v;
    endcase
  endfunction
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wide,
  input  logic [ADDR_W-1:0] offset,
  output target_e           tgt,
  output lane_e             lane
);
  localparam int WORD_W = ADDR_W - 3;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = offset[ADDR_W-1:3];
  assign aligned = (offset[1:0] == 2'b00) && !(wide && offset[2]);

  always_comb begin
    tgt = TGT_NONE;
    if (aligned) begin
      if (word == WORD_W'(CTRL_WORD))       tgt = TGT_CTRL;
      else if (word == WORD_W'(BASE_WORD))  tgt = TGT_BASE;
      else if (word == WORD_W'(FLUSH_WORD)) tgt = TGT_FLUSH;
    end
    if (wide)           lane = LANE_FULL;
    else if (offset[2]) lane = LANE_LO;
    else                lane = LANE_HI;
  end
endmodule

// File: rtl/cfgbank_reg.sv
module cfgbank_reg
  import cfgbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  lane_e            lane,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= merge_write(q, wdata, lane);
  end
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
(
  input  target_e          tgt,
  input  lane_e            lane,
  input  logic [REG_W-1:0] ctrl_v,
  input  logic [REG_W-1:0] base_v,
  output logic [REG_W-1:0] data
);
  always_comb begin
    case (tgt)
      TGT_CTRL: data = read_view(ctrl_v, lane);
      TGT_BASE: data = read_view(base_v, lane);
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/iommu_cfg_bank.sv
module iommu_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_wide,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [63:0]       acc_wdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              bad_access,
  output logic [63:0]       walker_ctrl,
  output logic [63:0]       walker_base
);
  target_e          dec_tgt;
  lane_e            dec_lane;
  logic [NREGS-1:0] wr_hit;
  logic [REG_W-1:0] reg_q [NREGS];
  logic [REG_W-1:0] mux_data;
  logic             rd_fire;
  logic             unmapped_evt;
  logic             flush_wr_evt;

  cfgbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wide(acc_wide), .offset(acc_offset), .tgt(dec_tgt), .lane(dec_lane)
  );

  assign rd_fire      = acc_valid && !acc_write;
  assign unmapped_evt = acc_valid && (dec_tgt == TGT_NONE);
  assign flush_wr_evt = acc_valid && acc_write && (dec_tgt == TGT_FLUSH);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    assign wr_hit[g] = acc_valid && acc_write && (dec_tgt == target_e'(g));
    cfgbank_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[g]), .lane(dec_lane),
      .wdata(acc_wdata), .q(reg_q[g])
    );
  end

  assign walker_ctrl = reg_q[CTRL_WORD];
  assign walker_base = reg_q[BASE_WORD];

  cfgbank_rdmux u_rdmux (
    .tgt(dec_tgt), .lane(dec_lane), .ctrl_v(walker_ctrl),
    .base_v(walker_base), .data(mux_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      bad_access <= 1'b0;
    end else begin
      rd_valid   <= rd_fire;
      rd_data    <= rd_fire ? mux_data : '0;
      bad_access <= unmapped_evt;
    end
  end

  AST_WIDE_WRITE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_wide && acc_offset == '0) |=> walker_ctrl == $past(acc_wdata)); // R1
  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[0] && dec_lane == LANE_HI) |=> walker_ctrl[31:0] == $past(walker_ctrl[31:0])); // R2
  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[1] && dec_lane == LANE_LO) |=> walker_base[63:32] == $past(walker_base[63:32])); // R3
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid); // R4
  AST_FLUSH_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr_evt |=> ($stable(walker_ctrl) && $stable(walker_base) && !bad_access)); // R5
  AST_UNMAPPED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_evt |=> bad_access); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_evt && !acc_write) |=> rd_data == '0); // R7
endmodule

// File: tb/test_iommu_cfg_bank.sv
module test_iommu_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [7:0]  acc_offset = '0;
  logic [63:0] acc_wdata = '0;
  logic        rd_valid, bad_access;
  logic [63:0] rd_data, walker_ctrl, walker_base;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [63:0] m_ctrl = '0, m_base = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  iommu_cfg_bank i_iommu_cfg_bank (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .bad_access(bad_access),
    .walker_ctrl(walker_ctrl), .walker_base(walker_base)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected rd_valid", 64'd1, 64'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // bench-side model of the address map
  function automatic int kind(input bit wide, input logic [7:0] off);
    if (off[1:0] != 2'b00 || (wide && off[2])) return 3;
    if (off[7:3] == 5'd0) return 0;
    if (off[7:3] == 5'd1) return 1;
    if (off[7:3] == 5'd2) return 2;
    return 3;
  endfunction

  task automatic access(input string req, input bit wr, input bit wide,
                        input logic [7:0] off, input logic [63:0] wd);
    int k;
    logic [63:0] cur, nv, rv;
    k = kind(wide, off);
    cur = (k == 0) ? m_ctrl : (k == 1) ? m_base : 64'd0;
    if (wide) nv = wd;
    else if (off[2]) nv = {cur[63:32], wd[31:0]};
    else nv = {wd[31:0], cur[31:0]};
    if (wide) rv = cur;
    else if (off[2]) rv = {32'd0, cur[31:0]};
    else rv = {32'd0, cur[63:32]};
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_wide = wide; acc_offset = off; acc_wdata = wd;
    if (!wr) begin exp_q.push_back(rv); tag_q.push_back(req); end
    if (wr && k == 0) m_ctrl = nv;
    if (wr && k == 1) m_base = nv;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    chk({req, " bad_access"}, {63'd0, bad_access}, {63'd0, (k == 3)});
    chk({req, " walker_ctrl"}, walker_ctrl, m_ctrl);
    chk({req, " walker_base"}, walker_base, m_base);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset ctrl", walker_ctrl, 64'd0);
    chk("R6 reset base", walker_base, 64'd0);
    chk("R6 reset rd_valid", {63'd0, rd_valid}, 64'd0);
    rst_n = 1;
    access("R6 read ctrl after reset", 0, 1, 8'h00, 0);
    access("R1 wide write ctrl", 1, 1, 8'h00, 64'h1122334455667788);
    access("R1 wide write base", 1, 1, 8'h08, 64'hA5A5_0F0F_C3C3_9696);
    access("R4 wide read ctrl", 0, 1, 8'h00, 0);
    access("R4 wide read base", 0, 1, 8'h08, 0);
    access("R2 hi write ctrl", 1, 0, 8'h00, 64'hFFFF_FFFF_DEAD_BEEF);
    access("R2 hi write base", 1, 0, 8'h08, 64'h0000_0000_0BAD_F00D);
    access("R3 lo write ctrl", 1, 0, 8'h04, 64'hFFFF_FFFF_CAFE_0001);
    access("R3 lo write base", 1, 0, 8'h0C, 64'h0000_0000_1234_5678);
    access("R4 hi read ctrl", 0, 0, 8'h00, 0);
    access("R4 lo read ctrl", 0, 0, 8'h04, 0);
    access("R4 hi read base", 0, 0, 8'h08, 0);
    access("R4 lo read base", 0, 0, 8'h0C, 0);
    access("R5 flush wide write", 1, 1, 8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    access("R5 flush hi write", 1, 0, 8'h10, 64'h0000_0000_FFFF_FFFF);
    access("R5 flush lo write", 1, 0, 8'h14, 64'h0000_0000_FFFF_FFFF);
    access("R5 flush read", 0, 1, 8'h10, 0);
    access("R5 flush lo read", 0, 0, 8'h14, 0);
    access("R7 write out of range", 1, 1, 8'h18, 64'h0123_4567_89AB_CDEF);
    access("R7 write misaligned", 1, 0, 8'h02, 64'h0000_0000_7777_7777);
    access("R7 wide write at +4", 1, 1, 8'h0C, 64'h8888_8888_8888_8888);
    access("R7 read out of range", 0, 1, 8'h40, 0);
    access("R7 wide read at +4", 0, 1, 8'h04, 0);
    access("R7 read misaligned", 0, 0, 8'h09, 0);
    access("R4 final wide read ctrl", 0, 1, 8'h00, 0);
    access("R4 final wide read base", 0, 1, 8'h08, 0);
    @(negedge clk);
    chk("R4 rd_valid idle", {63'd0, rd_valid}, 64'd0);
    chk("R4 all reads returned", 64'(exp_q.size()), 64'd0);
    chk("R7 strobe one cycle", {63'd0, bad_access}, 64'd0);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R6 reset clears ctrl", walker_ctrl, 64'd0);
    chk("R6 reset clears base", walker_base, 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule